// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A memory-mapped watchdog that counts down in half-second ticks and, when it runs out, raises a one-cycle request to reset the system. Software starts the countdown by setting the enable bit or by writing a restart to the control register, and keeps the system alive by restarting it before the count reaches zero. A divider derived from the input clock produces the half-second tick.

One compile-time parameter, `KEYED`, selects between two register layouts that share the same countdown core. With `KEYED = 0` the layout is compact and any restart write is accepted. With `KEYED = 1` a restart must carry a 12-bit key in the same write, the reset-enable bit moves to a separate configuration word, and two plain storage words are added. The timeout length comes from a fixed nonlinear table indexed by a 4-bit field of the mode word.

Top module: `keyed_wdt`

## Requirements
- R1: While `rst_ni` is low every stored word is cleared to zero, the countdown stops and `sys_rst_o` is low; after release no request is raised until the countdown is started again.
- R2: With `KEYED = 1` the word offsets are: 0x00 and 0x04 plain read/write storage, 0x10 control, 0x14 configuration (plain read/write storage), 0x18 mode. The control word always reads zero. Any other offset reads zero and writes to it are ignored.
- R3: With `KEYED = 0` control is at 0x00 (reads zero), mode at 0x04, reset enable is mode bit 1, the interval index is mode bits [6:3], a control write with bit 0 set restarts with no key, and every other offset reads zero.
- R4: With `KEYED = 1` a control write restarts only when bit 0 is set and bits [12:1] equal 0xA57; any other control write has no effect on the countdown.
- R5: An accepted restart reloads the count and restarts the tick phase whether or not the watchdog is enabled; a count of N ticks expires on the N*PRESC_DIV-th rising clock edge after the accepting write edge, and the request is visible in the cycle after that edge.
- R6: Mode bit 0 is the enable bit; a mode write that takes it from 0 to 1 reloads and starts the countdown using the newly written index, while writing 1 over an existing 1 leaves the countdown untouched.
- R7: Interval index 0..11 selects 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28, 32 half-second ticks respectively.
- R8: An index of 12..15 leaves the current count unchanged but still restarts the countdown; a kept count of zero expires after one tick.
- R9: With `KEYED = 1` the interval index is mode bits [7:4] and reset enable is configuration bit 0; on expiry `sys_rst_o` pulses for exactly one cycle only if enable and reset enable are both set.
- R10: After expiry the countdown stops and does not reload by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte offset of the accessed word |
| we_i | input | 1 | Write strobe, one word per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The bench aims at the exact expiry edge for every table index, so a wrong table entry or an off-by-one in the divider shows up as a pulse on the wrong cycle. It sends a restart with a key one off and one with no restart bit, which a design that ignores the key would turn into a pulse. It rewrites the enable bit while already set and switches to an out-of-table index mid-countdown, catching a design that reloads on level rather than edge or that loads a garbage count. It also runs with the enable or reset-enable cleared, where a loosely gated design would still request a reset.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int          CNT_W   = 6;
  localparam int          IDX_W   = 4;
  localparam int          N_INTV  = 12;
  localparam logic [11:0] RST_KEY = 12'hA57;

  // half-second ticks per interval index; 0 for unmapped indices
  function automatic logic [CNT_W-1:0] intv_ticks(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:  return 6'd1;
      4'd1:  return 6'd2;
      4'd2:  return 6'd4;
      4'd3:  return 6'd6;
      4'd4:  return 6'd8;
      4'd5:  return 6'd10;
      4'd6:  return 6'd12;
      4'd7:  return 6'd16;
      4'd8:  return 6'd20;
      4'd9:  return 6'd24;
      4'd10: return 6'd28;
      4'd11: return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic intv_valid(input logic [IDX_W-1:0] idx);
    return 32'(idx) < N_INTV;
  endfunction
endpackage

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int PRESC_DIV = 62_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (run_i)   pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  p_pre_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);
  p_phase_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pre_q == '0));
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter bit KEYED  = 1'b1,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              load_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              en_o,
  output logic              rst_en_o
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(KEYED ? 'h10 : 'h00);
  localparam logic [ADDR_W-1:0] MODE_OFS = ADDR_W'(KEYED ? 'h18 : 'h04);
  localparam int IDX_LSB = KEYED ? 4 : 3;

  logic [31:0] mode_q;
  logic        wr_ctrl, wr_mode, key_ok, restart, en_rise;
  logic [31:0] idx_src;

  assign wr_ctrl = we_i && (addr_i == CTRL_OFS);
  assign wr_mode = we_i && (addr_i == MODE_OFS);
  assign key_ok  = KEYED ? (wdata_i[12:1] == RST_KEY) : 1'b1;
  assign restart = wr_ctrl && wdata_i[0] && key_ok;
  assign en_rise = wr_mode && wdata_i[0] && !mode_q[0];
  assign load_o  = restart || en_rise;
  // an enabling mode write uses the index it carries
  assign idx_src = wr_mode ? wdata_i : mode_q;
  assign idx_o   = idx_src[IDX_LSB +: IDX_W];
  assign en_o    = mode_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (wr_mode) mode_q <= wdata_i;
  end

  generate
    if (KEYED) begin : g_keyed
      localparam logic [ADDR_W-1:0] IEN_OFS = ADDR_W'('h00);
      localparam logic [ADDR_W-1:0] IST_OFS = ADDR_W'('h04);
      localparam logic [ADDR_W-1:0] CFG_OFS = ADDR_W'('h14);
      logic [31:0] ien_q, ist_q, cfg_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ien_q <= '0;
          ist_q <= '0;
          cfg_q <= '0;
        end else if (we_i) begin
          if (addr_i == IEN_OFS) ien_q <= wdata_i;
          if (addr_i == IST_OFS) ist_q <= wdata_i;
          if (addr_i == CFG_OFS) cfg_q <= wdata_i;
        end
      end

      assign rst_en_o = cfg_q[0];

      always_comb begin
        rdata_o = '0;
        if (addr_i == IEN_OFS)  rdata_o = ien_q;
        if (addr_i == IST_OFS)  rdata_o = ist_q;
        if (addr_i == CFG_OFS)  rdata_o = cfg_q;
        if (addr_i == MODE_OFS) rdata_o = mode_q;
      end
    end else begin : g_plain
      assign rst_en_o = mode_q[1];

      always_comb begin
        rdata_o = '0;
        if (addr_i == MODE_OFS) rdata_o = mode_q;
      end
    end
  endgenerate

  p_ctrl_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == CTRL_OFS) |-> (rdata_o == '0));
  p_bad_key_no_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && KEYED && (wdata_i[12:1] != RST_KEY)) |-> !load_o);
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             rst_en_i,
  output logic             run_o,
  output logic             sys_rst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (load_i) begin
        if (intv_valid(idx_i)) cnt_q <= intv_ticks(idx_i);
        run_q <= 1'b1;
      end else if (tick_i && run_q) begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_q <= '0;
          run_q <= 1'b0;
          req_q <= en_i && rst_en_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign run_o     = run_q;
  assign sys_rst_o = req_q;

  p_req_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);
  p_req_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> $past(en_i && rst_en_i));
  p_halt_after_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !run_q);
  p_cnt_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(32));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter bit KEYED     = 1'b1,
  parameter int PRESC_DIV = 62_500_000,
  parameter int ADDR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sys_rst_o
);
  logic             load, en, rst_en, run, tick;
  logic [IDX_W-1:0] idx;

  kwdt_regs #(.KEYED(KEYED), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .load_o(load), .idx_o(idx), .en_o(en), .rst_en_o(rst_en)
  );

  kwdt_prescale #(.PRESC_DIV(PRESC_DIV)) u_pre (
    .clk_i, .rst_ni, .clear_i(load), .run_i(run), .tick_o(tick)
  );

  kwdt_count u_cnt (
    .clk_i, .rst_ni, .load_i(load), .idx_i(idx), .tick_i(tick),
    .en_i(en), .rst_en_i(rst_en), .run_o(run), .sys_rst_o
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !sys_rst_o);
endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  localparam int DIV = 4;
  localparam int TBL [12] = '{1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28, 32};
  localparam logic [31:0] KEYW = (32'hA57 << 1) | 32'h1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  b_addr = '0, a_addr = '0;
  logic        b_we = 1'b0, a_we = 1'b0;
  logic [31:0] b_wdata = '0, a_wdata = '0, b_rdata, a_rdata;
  logic        b_req, a_req;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  keyed_wdt #(.KEYED(1'b1), .PRESC_DIV(DIV), .ADDR_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(b_addr), .we_i(b_we),
    .wdata_i(b_wdata), .rdata_o(b_rdata), .sys_rst_o(b_req));

  keyed_wdt #(.KEYED(1'b0), .PRESC_DIV(DIV), .ADDR_W(8)) dut_a (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(a_addr), .we_i(a_we),
    .wdata_i(a_wdata), .rdata_o(a_rdata), .sys_rst_o(a_req));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel_a, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    if (sel_a) begin a_addr = a; a_wdata = d; a_we = 1'b1; end
    else       begin b_addr = a; b_wdata = d; b_we = 1'b1; end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd(input bit sel_a, input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    if (sel_a) a_addr = a; else b_addr = a;
    #1;
    if (sel_a) check(a_rdata == exp, req, int'(a_rdata), int'(exp));
    else       check(b_rdata == exp, req, int'(b_rdata), int'(exp));
  endtask

  // edge (counted after the last write edge) of the single pulse; -1 = none
  task automatic expect_pulse(input bit sel_a, input int edges, input int window, input string req);
    int first = -1, highs = 0;
    for (int e = 1; e <= window; e++) begin
      @(posedge clk); #1;
      if (sel_a ? a_req : b_req) begin
        highs++;
        if (first < 0) first = e;
      end
    end
    check(first == edges && highs == (edges < 0 ? 0 : 1), req, first, edges);
  endtask

  initial begin
    for (;;) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(b_req == 1'b0 && a_req == 1'b0, "R1 req low in reset", int'(b_req), 0);
    rst_n = 1'b1;
    rd(1'b0, 8'h18, 32'h0, "R1 mode clear");
    rd(1'b0, 8'h14, 32'h0, "R1 cfg clear");
    expect_pulse(1'b0, -1, 40, "R1 idle after reset");

    // R2 storage and decode
    wr(1'b0, 8'h00, 32'hDEAD_BEEF);
    wr(1'b0, 8'h04, 32'h1234_5678);
    rd(1'b0, 8'h00, 32'hDEAD_BEEF, "R2 word 0x00");
    rd(1'b0, 8'h04, 32'h1234_5678, "R2 word 0x04");
    wr(1'b0, 8'h10, KEYW & ~32'h1);
    rd(1'b0, 8'h10, 32'h0, "R2 control reads zero");
    wr(1'b0, 8'h08, 32'hFFFF_FFFF);
    rd(1'b0, 8'h08, 32'h0, "R2 unmapped 0x08");
    wr(1'b0, 8'h40, 32'hFFFF_FFFF);
    rd(1'b0, 8'h40, 32'h0, "R2 unmapped 0x40");
    rd(1'b0, 8'h00, 32'hDEAD_BEEF, "R2 unmapped write ignored");
    wr(1'b0, 8'h14, 32'h1);
    rd(1'b0, 8'h14, 32'h1, "R2 cfg storage");

    // R7 table walk: enable rising with each index
    for (int i = 0; i < 12; i++) begin
      wr(1'b0, 8'h18, 32'h0);
      wr(1'b0, 8'h18, (32'(i) << 4) | 32'h1);
      expect_pulse(1'b0, TBL[i] * DIV, TBL[i] * DIV + 3, $sformatf("R7 index %0d", i));
    end

    // R10 stopped after expiry: no further pulse
    expect_pulse(1'b0, -1, 150, "R10 no self reload");

    // R4 bad key, missing restart bit, then good key
    wr(1'b0, 8'h10, KEYW ^ 32'h2);
    expect_pulse(1'b0, -1, 150, "R4 wrong key ignored");
    wr(1'b0, 8'h10, KEYW & ~32'h1);
    expect_pulse(1'b0, -1, 150, "R4 no restart bit ignored");
    wr(1'b0, 8'h10, KEYW);
    expect_pulse(1'b0, 32 * DIV, 32 * DIV + 3, "R4 keyed restart");

    // R5 restart mid-countdown pushes expiry out
    wr(1'b0, 8'h18, 32'h0);
    wr(1'b0, 8'h18, (32'd1 << 4) | 32'h1);
    repeat (5) @(posedge clk);
    wr(1'b0, 8'h10, KEYW);
    expect_pulse(1'b0, 2 * DIV, 2 * DIV + 3, "R5 restart reloads");

    // R6 rewriting enable=1 does not reload
    wr(1'b0, 8'h18, 32'h0);
    wr(1'b0, 8'h18, (32'd1 << 4) | 32'h1);
    repeat (2) @(posedge clk);
    wr(1'b0, 8'h18, (32'd1 << 4) | 32'h1);
    expect_pulse(1'b0, 2 * DIV - 3, 2 * DIV + 3, "R6 no reload on level");

    // R8 out-of-table index keeps the running count
    wr(1'b0, 8'h18, 32'h0);
    wr(1'b0, 8'h18, (32'd3 << 4) | 32'h1);
    repeat (8) @(posedge clk);
    wr(1'b0, 8'h18, (32'd12 << 4) | 32'h1);
    wr(1'b0, 8'h10, KEYW);
    expect_pulse(1'b0, 4 * DIV, 6 * DIV + 3, "R8 count kept on restart");
    // R8 kept count of zero expires after one tick
    wr(1'b0, 8'h18, 32'h0);
    wr(1'b0, 8'h18, (32'd13 << 4) | 32'h1);
    expect_pulse(1'b0, DIV, DIV + 3, "R8 zero count one tick");

    // R9 gating: reset enable clear, then enable clear with restart
    wr(1'b0, 8'h14, 32'h0);
    wr(1'b0, 8'h18, 32'h0);
    wr(1'b0, 8'h18, 32'h1);
    expect_pulse(1'b0, -1, 3 * DIV, "R9 no pulse without reset enable");
    wr(1'b0, 8'h14, 32'h1);
    wr(1'b0, 8'h18, 32'h0);
    wr(1'b0, 8'h10, KEYW);
    expect_pulse(1'b0, -1, 3 * DIV, "R9 no pulse while disabled");
    // R9 index field is bits [7:4]: bit 3 set must not change the timeout
    wr(1'b0, 8'h18, (32'd2 << 4) | 32'h8 | 32'h1);
    expect_pulse(1'b0, 4 * DIV, 4 * DIV + 3, "R9 index field position");

    // R3 compact layout
    wr(1'b1, 8'h04, (32'd2 << 3) | 32'h3);
    expect_pulse(1'b1, 4 * DIV, 4 * DIV + 3, "R3 enable with index bits 6:3");
    wr(1'b1, 8'h00, 32'h1);
    expect_pulse(1'b1, 4 * DIV, 4 * DIV + 3, "R3 keyless restart");
    rd(1'b1, 8'h04, (32'd2 << 3) | 32'h3, "R3 mode readback");
    rd(1'b1, 8'h00, 32'h0, "R3 control reads zero");
    rd(1'b1, 8'h14, 32'h0, "R3 unmapped reads zero");
    wr(1'b1, 8'h04, (32'd2 << 3) | 32'h1);
    wr(1'b1, 8'h00, 32'h1);
    expect_pulse(1'b1, -1, 6 * DIV, "R3 reset enable is mode bit 1");

    // R1 reset mid-countdown
    wr(1'b0, 8'h18, 32'h0);
    wr(1'b0, 8'h18, 32'h1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, 8'h18, 32'h0, "R1 mode cleared by reset");
    rd(1'b0, 8'h00, 32'h0, "R1 storage cleared by reset");
    expect_pulse(1'b0, -1, 4 * DIV, "R1 countdown stopped by reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule